// File: doc/BRIEF.md
# Disk Sector Read Sequencer

This block pulls one chosen sector off a spinning disk. The read channel hands it recovered bits as a one-cycle strobe with a bit value beside it. A separate pulse marks the start of each sector, and a counter elsewhere supplies the number of the sector now passing the head. When a sector-start pulse arrives while that number equals the requested sector, the sequencer arms itself. It then reads the three records of the sector in turn: header, then label, then data.

Each record begins with a fixed quiet interval, counted in clock cycles, during which every incoming bit is ignored. After that the sequencer hunts for the sync mark, which is a run of zero bits ended by a single one. The bits that follow are packed into 16-bit words, most significant bit first. Every record word is written to a word-addressed RAM port at the next address after the previous one, starting from a base address given at arming time. The word that follows each record is its recorded checksum. It is compared against an XOR checksum that the block accumulates over that record. A mismatch, or a sync hunt that takes too long, ends the read with an error. A clean data record ends it with done.

Top module: `sector_read_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `ramWe` are all low and no RAM write occurs until a read is armed.
- R2: A read is armed only by a `sectorMark` pulse seen while `sectorCount` equals `targetSector`; a pulse with any other count leaves `busy` low and writes nothing.
- R3: During the first `PRE_CYC` cycles of each record, counted from arming or from the cycle after the previous record's checksum completes, received bits are ignored: a complete sync pattern in that window does not start word assembly.
- R4: Sync is found only when a 1 bit follows at least 15 consecutive 0 bits received during the hunt; a 1 after 14 zeros is not sync. The first data bit is the bit after that 1.
- R5: Words are 16 bits, first-received bit as bit 15. The record words of a sector (header `HDR_WORDS`, label `LBL_WORDS`, data `DAT_WORDS`; 266 with defaults) go to consecutive addresses starting at `baseAddr`, one single-cycle `ramWe` per word. Checksum words are never written.
- R6: Each record's checksum is `CK_SEED` XORed with every word of that record only, restarted at each record; a match lets the read continue to the next record.
- R7: If a recorded checksum differs from the computed one, `error` is raised, `busy` drops and no further RAM writes occur for that sector.
- R8: If sync is not found within `SYNC_TIMEOUT` cycles of the hunt starting, `error` is raised. A sync 1-bit arriving in the very cycle the limit expires still counts as sync.
- R9: `done` rises after the data record's checksum matches. `done` and `error` hold until the next armed read, which clears them and can use a new base address.
- R10: `sectorMark` pulses arriving while a read is in progress are ignored: the read runs on without restarting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sectorMark | input | 1 | One-cycle pulse at the start of each sector |
| sectorCount | input | SEC_W | Number of the sector now under the head |
| targetSector | input | SEC_W | Sector to be read |
| baseAddr | input | ADDR_W | RAM address for the first header word, latched at arming |
| rdStrobe | input | 1 | One-cycle strobe: a recovered bit is valid on `rdBit` |
| rdBit | input | 1 | Recovered bit value |
| ramWe | output | 1 | One-cycle RAM write enable |
| ramAddr | output | ADDR_W | RAM write address |
| ramData | output | 16 | RAM write data |
| busy | output | 1 | A sector read is in progress |
| done | output | 1 | Last read finished with all checksums matching |
| error | output | 1 | Last read stopped on checksum mismatch or sync timeout |

## Verification
Two things can land on the same clock edge: the sync-hunt deadline running out, and the closing 1 bit of the sync mark. The bench arms a read and holds the strobes back. It then places a run of 15 zeros so that the final 1 is sampled exactly on the cycle the deadline expires, and in a second run one cycle later. The first placement must leave the read busy with no error, because sync wins the tie. The second must raise `error`.

// File: rtl/secrd_pkg.sv
package secrd_pkg;

  localparam int WORD_W     = 16;
  localparam int SYNC_ZEROS = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HUNT,
    ST_WORDS,
    ST_DONE,
    ST_ERR
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBase;  // latch base address
    logic clrRec;    // restart record: checksum, counters, timer
    logic clrTimer;  // restart the cycle timer only
    logic huntEn;    // track zero run for sync
    logic shiftEn;   // assemble word bits
    logic wrWord;    // commit assembled word to RAM
  } dpCtrl_t;

endpackage

// File: rtl/secrd_datapath.sv
module secrd_datapath
  import secrd_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int HDR_WORDS    = 2,
  parameter int LBL_WORDS    = 8,
  parameter int DAT_WORDS    = 256,
  parameter int PRE_CYC      = 200,
  parameter int SYNC_TIMEOUT = 2000,
  parameter logic [15:0] CK_SEED = 16'h5A5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [1:0]        recIdx,
  input  logic              rdStrobe,
  input  logic              rdBit,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              preDone,
  output logic              huntTimeout,
  output logic              syncHit,
  output logic              wordFull,
  output logic              lastWord,
  output logic              ckMatch,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [WORD_W-1:0] ramData
);

  localparam int MAX_LEN  = (DAT_WORDS > LBL_WORDS) ?
                            ((DAT_WORDS > HDR_WORDS) ? DAT_WORDS : HDR_WORDS) :
                            ((LBL_WORDS > HDR_WORDS) ? LBL_WORDS : HDR_WORDS);
  localparam int CNT_W    = $clog2(MAX_LEN + 1);
  localparam int TMAX     = (PRE_CYC > SYNC_TIMEOUT) ? PRE_CYC : SYNC_TIMEOUT;
  localparam int TIMER_W  = $clog2(TMAX + 1);
  localparam int TOTAL    = HDR_WORDS + LBL_WORDS + DAT_WORDS;
  localparam int BIT_W    = $clog2(WORD_W);
  localparam logic [TIMER_W-1:0] PRE_LAST = TIMER_W'(PRE_CYC - 1);
  localparam logic [TIMER_W-1:0] TO_LAST  = TIMER_W'(SYNC_TIMEOUT - 1);
  localparam logic [3:0]         RUN_MAX  = 4'(SYNC_ZEROS);

  logic [TIMER_W-1:0] cycCnt;
  logic [3:0]         zeroRun;
  logic [WORD_W-1:0]  shiftReg;
  logic [BIT_W-1:0]   bitCnt;
  logic [CNT_W-1:0]   wordCnt;
  logic [CNT_W-1:0]   curLen;
  logic [WORD_W-1:0]  ckAcc;
  logic [ADDR_W-1:0]  nextAddr;
  logic [ADDR_W-1:0]  baseHold;

  always_comb begin
    case (recIdx)
      2'd0:    curLen = CNT_W'(HDR_WORDS);
      2'd1:    curLen = CNT_W'(LBL_WORDS);
      default: curLen = CNT_W'(DAT_WORDS);
    endcase
  end

  // shared cycle timer: preamble length, then sync-hunt deadline
  always_ff @(posedge clk) begin
    if (!rstN)                            cycCnt <= '0;
    else if (ctrl.clrRec || ctrl.clrTimer) cycCnt <= '0;
    else if (cycCnt != '1)                cycCnt <= cycCnt + 1'b1;
  end

  assign preDone     = (cycCnt == PRE_LAST);
  assign huntTimeout = (cycCnt == TO_LAST);

  // zero-run tracker for sync detection
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clrRec) zeroRun <= '0;
    else if (ctrl.huntEn && rdStrobe) begin
      if (rdBit)                  zeroRun <= '0;
      else if (zeroRun != RUN_MAX) zeroRun <= zeroRun + 1'b1;
    end
  end

  assign syncHit = ctrl.huntEn && rdStrobe && rdBit && (zeroRun == RUN_MAX);

  // bit assembly, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      wordFull <= 1'b0;
    end else begin
      wordFull <= ctrl.shiftEn && rdStrobe && (bitCnt == '1);
      if (ctrl.clrRec) bitCnt <= '0;
      else if (ctrl.shiftEn && rdStrobe) begin
        shiftReg <= {shiftReg[WORD_W-2:0], rdBit};
        bitCnt   <= bitCnt + 1'b1;
      end
    end
  end

  // per-record word count and checksum
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt <= '0;
      ckAcc   <= CK_SEED;
    end else if (ctrl.clrRec) begin
      wordCnt <= '0;
      ckAcc   <= CK_SEED;
    end else if (ctrl.wrWord) begin
      wordCnt <= wordCnt + 1'b1;
      ckAcc   <= ckAcc ^ shiftReg;
    end
  end

  assign lastWord = (wordCnt == curLen);
  assign ckMatch  = (shiftReg == ckAcc);

  // RAM port and address stepping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddr <= '0;
      baseHold <= '0;
      ramWe    <= 1'b0;
      ramAddr  <= '0;
      ramData  <= '0;
    end else begin
      ramWe <= ctrl.wrWord;
      if (ctrl.loadBase) begin
        nextAddr <= baseAddr;
        baseHold <= baseAddr;
      end else if (ctrl.wrWord) begin
        nextAddr <= nextAddr + 1'b1;
      end
      if (ctrl.wrWord) begin
        ramAddr <= nextAddr;
        ramData <= shiftReg;
      end
    end
  end

  // R5: one enable per word, never back to back
  assert_single_we_R5: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> !ramWe);

  // R5: every write lands inside the sector window above the base
  assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ADDR_W'(ramAddr - baseHold) < ADDR_W'(TOTAL)));

  // R6: a record word is committed only while the record is not yet full
  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrWord |-> (wordCnt < curLen));

endmodule

// File: rtl/secrd_control.sv
module secrd_control
  import secrd_pkg::*;
#(
  parameter int SEC_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sectorMark,
  input  logic [SEC_W-1:0] sectorCount,
  input  logic [SEC_W-1:0] targetSector,
  input  logic             preDone,
  input  logic             huntTimeout,
  input  logic             syncHit,
  input  logic             wordFull,
  input  logic             lastWord,
  input  logic             ckMatch,
  output dpCtrl_t          ctrl,
  output logic [1:0]       recIdx,
  output logic             busy,
  output logic             done,
  output logic             error
);

  seqState_t state, stateNext;
  logic      recClr, recInc, armHit;

  assign armHit = sectorMark && (sectorCount == targetSector);

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    recClr    = 1'b0;
    recInc    = 1'b0;
    case (state)
      ST_IDLE, ST_DONE, ST_ERR: begin
        if (armHit) begin
          stateNext     = ST_PRE;
          ctrl.clrRec   = 1'b1;
          ctrl.loadBase = 1'b1;
          recClr        = 1'b1;
        end
      end
      ST_PRE: begin
        if (preDone) begin
          stateNext     = ST_HUNT;
          ctrl.clrTimer = 1'b1;
        end
      end
      ST_HUNT: begin
        ctrl.huntEn = 1'b1;
        if (syncHit)          stateNext = ST_WORDS;
        else if (huntTimeout) stateNext = ST_ERR;
      end
      ST_WORDS: begin
        ctrl.shiftEn = 1'b1;
        if (wordFull) begin
          if (!lastWord) begin
            ctrl.wrWord = 1'b1;
          end else if (!ckMatch) begin
            stateNext = ST_ERR;
          end else if (recIdx == 2'd2) begin
            stateNext = ST_DONE;
          end else begin
            stateNext   = ST_PRE;
            ctrl.clrRec = 1'b1;
            recInc      = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      recIdx <= '0;
    end else begin
      state <= stateNext;
      if (recClr)      recIdx <= '0;
      else if (recInc) recIdx <= recIdx + 1'b1;
    end
  end

  assign busy  = (state == ST_PRE) || (state == ST_HUNT) || (state == ST_WORDS);
  assign done  = (state == ST_DONE);
  assign error = (state == ST_ERR);

  // R2: a read only starts after a matching sector mark
  assert_arm_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(sectorMark) && $past(sectorCount == targetSector)));

  // R6: done follows a matching checksum on a full record
  assert_done_on_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(ckMatch) && $past(lastWord)));

  // R7: a bad checksum stops the read with an error
  assert_bad_ck_error_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WORDS && wordFull && lastWord && !ckMatch) |=> error);

  // R8: deadline without sync gives error
  assert_hunt_timeout_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT && huntTimeout && !syncHit) |=> error);

  // R9: outcome flags are exclusive
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, done, error}));

endmodule

// File: rtl/sector_read_seq.sv
module sector_read_seq
  import secrd_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SEC_W        = 4,
  parameter int HDR_WORDS    = 2,
  parameter int LBL_WORDS    = 8,
  parameter int DAT_WORDS    = 256,
  parameter int PRE_CYC      = 200,
  parameter int SYNC_TIMEOUT = 2000,
  parameter logic [15:0] CK_SEED = 16'h5A5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sectorMark,
  input  logic [SEC_W-1:0]  sectorCount,
  input  logic [SEC_W-1:0]  targetSector,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              rdStrobe,
  input  logic              rdBit,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [15:0]       ramData,
  output logic              busy,
  output logic              done,
  output logic              error
);

  dpCtrl_t    ctrl;
  logic [1:0] recIdx;
  logic       preDone, huntTimeout, syncHit, wordFull, lastWord, ckMatch;

  secrd_control #(.SEC_W(SEC_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sectorMark   (sectorMark),
    .sectorCount  (sectorCount),
    .targetSector (targetSector),
    .preDone      (preDone),
    .huntTimeout  (huntTimeout),
    .syncHit      (syncHit),
    .wordFull     (wordFull),
    .lastWord     (lastWord),
    .ckMatch      (ckMatch),
    .ctrl         (ctrl),
    .recIdx       (recIdx),
    .busy         (busy),
    .done         (done),
    .error        (error)
  );

  secrd_datapath #(
    .ADDR_W       (ADDR_W),
    .HDR_WORDS    (HDR_WORDS),
    .LBL_WORDS    (LBL_WORDS),
    .DAT_WORDS    (DAT_WORDS),
    .PRE_CYC      (PRE_CYC),
    .SYNC_TIMEOUT (SYNC_TIMEOUT),
    .CK_SEED      (CK_SEED)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .recIdx      (recIdx),
    .rdStrobe    (rdStrobe),
    .rdBit       (rdBit),
    .baseAddr    (baseAddr),
    .preDone     (preDone),
    .huntTimeout (huntTimeout),
    .syncHit     (syncHit),
    .wordFull    (wordFull),
    .lastWord    (lastWord),
    .ckMatch     (ckMatch),
    .ramWe       (ramWe),
    .ramAddr     (ramAddr),
    .ramData     (ramData)
  );

endmodule

// File: tb/sector_read_seq_tb.sv
module sector_read_seq_tb;

  localparam int ADDR_W = 16;
  localparam int SEC_W  = 4;
  localparam int HDR    = 2;
  localparam int LBL    = 8;
  localparam int DAT    = 256;
  localparam int TOTAL  = HDR + LBL + DAT;
  localparam int PRE    = 80;
  localparam int TMO    = 140;
  localparam logic [15:0] SEED = 16'hA5C3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sectorMark = 1'b0;
  logic [SEC_W-1:0]  sectorCount = '0;
  logic [SEC_W-1:0]  targetSector = '0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic              rdStrobe = 1'b0;
  logic              rdBit = 1'b0;
  logic              ramWe;
  logic [ADDR_W-1:0] ramAddr;
  logic [15:0]       ramData;
  logic              busy, done, error;

  int checks = 0;
  int fails  = 0;
  int nWr    = 0;
  logic [ADDR_W-1:0] gotAddr [0:2047];
  logic [15:0]       gotData [0:2047];

  always #4 clk = ~clk;  // 125 MHz

  sector_read_seq #(
    .ADDR_W(ADDR_W), .SEC_W(SEC_W), .HDR_WORDS(HDR), .LBL_WORDS(LBL),
    .DAT_WORDS(DAT), .PRE_CYC(PRE), .SYNC_TIMEOUT(TMO), .CK_SEED(SEED)
  ) u_dut (
    .clk(clk), .rstN(rstN), .sectorMark(sectorMark), .sectorCount(sectorCount),
    .targetSector(targetSector), .baseAddr(baseAddr), .rdStrobe(rdStrobe),
    .rdBit(rdBit), .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .busy(busy), .done(done), .error(error)
  );

  // RAM write monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN && ramWe) begin
      if (nWr < 2048) begin
        gotAddr[nWr] = ramAddr;
        gotData[nWr] = ramData;
      end
      nWr = nWr + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] genWord(input logic [15:0] s, input int idx);
    logic [15:0] i16;
    i16 = 16'(idx);
    return 16'(i16 * 16'h9E37 + s) ^ {i16[7:0], ~i16[7:0]};
  endfunction

  task automatic doReset();
    rstN = 1'b0; sectorMark = 1'b0; rdStrobe = 1'b0; rdBit = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // pulse the sector mark; returns on the following negedge
  task automatic pulseMark();
    sectorMark = 1'b1;
    @(negedge clk);
    sectorMark = 1'b0;
  endtask

  // one bit every 4 cycles, strobe seen at exactly one rising edge
  task automatic sendBit(input logic b);
    rdStrobe = 1'b1; rdBit = b;
    @(negedge clk);
    rdStrobe = 1'b0; rdBit = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendZeros(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) sendBit(w[i]);
  endtask

  // full sector bit stream; corruptRec = record with bad checksum (-1 none)
  task automatic sendSector(input logic [15:0] s, input int corruptRec,
                            input bit fakeSync, input bit shortSync);
    for (int rec = 0; rec < 3; rec++) begin
      int len, off;
      logic [15:0] ck;
      len = (rec == 0) ? HDR : (rec == 1) ? LBL : DAT;
      off = (rec == 0) ? 0 : (rec == 1) ? HDR : HDR + LBL;
      if (rec == 0 && fakeSync) begin
        sendZeros(15); sendBit(1'b1);   // full sync pattern inside preamble
        sendZeros(4);
      end else begin
        sendZeros(22);
      end
      if (rec == 0 && shortSync) begin
        sendBit(1'b1); sendZeros(14); sendBit(1'b1);  // only 14 zeros
      end
      sendZeros(15); sendBit(1'b1);
      ck = SEED;
      for (int i = 0; i < len; i++) begin
        ck = ck ^ genWord(s, off + i);
        sendWord(genWord(s, off + i));
      end
      if (rec == corruptRec) ck = ck ^ 16'h0100;
      sendWord(ck);
    end
  endtask

  task automatic checkSector(input string req, input int start,
                             input logic [ADDR_W-1:0] base, input logic [15:0] s);
    int aErr, dErr;
    aErr = 0; dErr = 0;
    chk(req, "write count", nWr - start, TOTAL);
    for (int i = 0; i < TOTAL; i++) begin
      if (gotAddr[start + i] != ADDR_W'(base + ADDR_W'(i))) aErr++;
      if (gotData[start + i] != genWord(s, i)) dErr++;
    end
    chk(req, "address mismatches", aErr, 0);
    chk(req, "data mismatches", dErr, 0);
  endtask

  task automatic armFor(input logic [ADDR_W-1:0] base);
    sectorCount = 4'd5; targetSector = 4'd5; baseAddr = base;
    pulseMark();
  endtask

  task automatic t_reset();
    doReset();
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "error", error, 0);
    chk("R1", "ramWe", ramWe, 0);
  endtask

  task automatic t_wrongSector();
    int start;
    doReset();
    start = nWr;
    sectorCount = 4'd3; targetSector = 4'd5;
    pulseMark();
    sendZeros(10);
    chk("R2", "busy after wrong-sector mark", busy, 0);
    chk("R2", "writes after wrong-sector mark", nWr - start, 0);
  endtask

  task automatic t_fullAndRearm();
    int start;
    doReset();
    start = nWr;
    armFor(16'h1000);
    chk("R2", "busy after matching mark", busy, 1);
    sendSector(16'h1234, -1, 1'b0, 1'b0);
    chk("R6", "done after clean sector", done, 1);
    chk("R6", "error after clean sector", error, 0);
    checkSector("R5", start, 16'h1000, 16'h1234);
    repeat (50) @(negedge clk);
    chk("R9", "done held while idle", done, 1);
    start = nWr;
    armFor(16'h2000);
    chk("R9", "done cleared by re-arm", done, 0);
    chk("R9", "busy after re-arm", busy, 1);
    sendSector(16'h4321, -1, 1'b0, 1'b0);
    chk("R9", "done after second sector", done, 1);
    checkSector("R9", start, 16'h2000, 16'h4321);
  endtask

  task automatic t_preambleIgnore();
    int start;
    doReset();
    start = nWr;
    armFor(16'h0300);
    sendSector(16'h0BEE, -1, 1'b1, 1'b0);
    chk("R3", "done with sync inside preamble", done, 1);
    checkSector("R3", start, 16'h0300, 16'h0BEE);
  endtask

  task automatic t_shortSync();
    int start;
    doReset();
    start = nWr;
    armFor(16'h0400);
    sendSector(16'h7777, -1, 1'b0, 1'b1);
    chk("R4", "done after 14-zero decoy", done, 1);
    checkSector("R4", start, 16'h0400, 16'h7777);
  endtask

  task automatic t_badChecksum();
    int start;
    doReset();
    start = nWr;
    armFor(16'h0500);
    sendSector(16'h2468, 1, 1'b0, 1'b0);
    chk("R7", "error on bad label checksum", error, 1);
    chk("R7", "done on bad label checksum", done, 0);
    chk("R7", "busy on bad label checksum", busy, 0);
    chk("R7", "writes stop after label", nWr - start, HDR + LBL);
  endtask

  task automatic t_timeout();
    int start;
    doReset();
    start = nWr;
    armFor(16'h0600);
    repeat (PRE + TMO + 5) @(negedge clk);
    chk("R8", "error on missing sync", error, 1);
    chk("R8", "writes on missing sync", nWr - start, 0);
  endtask

  // final sync 1 lands on deadline edge (lateBy=0) or one after (lateBy=1)
  task automatic t_syncDeadline(input int lateBy);
    int k;
    doReset();
    armFor(16'h0700);
    k = PRE + TMO - 60 + lateBy;
    repeat (k - 1) @(negedge clk);
    sendZeros(15); sendBit(1'b1);
    repeat (10) @(negedge clk);
    if (lateBy == 0) begin
      chk("R8", "error when sync meets deadline", error, 0);
      chk("R8", "busy when sync meets deadline", busy, 1);
    end else begin
      chk("R8", "error when sync misses deadline", error, 1);
    end
  endtask

  task automatic t_markDuringRead();
    int start;
    doReset();
    start = nWr;
    armFor(16'h0800);
    fork
      sendSector(16'h5555, -1, 1'b0, 1'b0);
      begin
        repeat (3000) @(negedge clk);
        pulseMark();
      end
    join
    chk("R10", "done despite mid-read mark", done, 1);
    checkSector("R10", start, 16'h0800, 16'h5555);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_wrongSector();
        t_fullAndRearm();
        t_preambleIgnore();
        t_shortSync();
        t_badChecksum();
        t_timeout();
        t_syncDeadline(0);
        t_syncDeadline(1);
        t_markDuringRead();
      end
      begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements) actual=expired expected=finished");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule